// File: doc/BRIEF.md
# Single-Wire Bus Device Responder

This block sits on the device side of an open-drain single-wire bus. It times every low pulse the master drives and sorts it by duration. A long pulse is a bus reset. A shorter pulse opens a write slot, and the block turns each slot into one data bit. After a reset ends, the block waits a fixed delay and then pulls the bus low itself for a fixed time, which tells the master that a device is present. All timing counts a one-microsecond tick that the surrounding chip supplies.

Decoded bits are packed least-significant first into words of `DATA_W` bits. Each finished word is offered on a valid/ready output. The bus cannot be held up, so the output never pushes back on the wire. A word stays offered until it is accepted. If a newer word finishes first, it replaces the older one. `drive_low` goes to the pad's open-drain enable. `reset_seen` is a one-cycle flag that is raised for every reset the block recognizes.

Top module: `swr_responder`

## Requirements
- R1: While `rst_n` is low, `drive_low`, `out_valid` and `reset_seen` are all 0.
- R2: A master low of at least `RST_MIN_US` ticks produces exactly one one-cycle `reset_seen` pulse when the bus rises again. A shorter low never raises `reset_seen`.
- R3: `drive_low` rises exactly `PRES_DELAY_US` ticks after the cycle that shows `reset_seen`. It then stays high for exactly `PRES_WIDTH_US` ticks.
- R4: A slot is sampled `SAMPLE_US` ticks after its falling edge. If the bus is back high by then, the slot decodes as bit 1. If the bus is still low, and it rises before `RST_MIN_US` ticks, the slot decodes as bit 0 and causes no reset.
- R5: The first decoded bit lands in `out_data[0]` and the last in `out_data[DATA_W-1]`. `out_valid` rises once every `DATA_W` bits.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value. A cycle with both signals at 1 accepts the word, and `out_valid` is 0 in the next cycle unless a new word finishes in that same cycle.
- R7: If a word finishes while an earlier one is still unaccepted, `out_data` takes the newer word and `out_valid` stays 1.
- R8: A recognized reset discards the bits of any partly collected word. The word that follows starts again at bit 0.
- R9: A falling edge is ignored from the `reset_seen` pulse until the presence pulse ends, whether the edge comes during the delay or during the pulse itself. Such an edge adds no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse once per microsecond |
| bus_in | input | 1 | Bus level from the pad (asynchronous) |
| drive_low | output | 1 | 1 pulls the bus low through the open-drain pad |
| reset_seen | output | 1 | One-cycle pulse when a bus reset ends |
| out_valid | output | 1 | A decoded word is offered |
| out_ready | input | 1 | Consumer accepts the offered word |
| out_data | output | DATA_W | Decoded word, first bit in bit 0 |

## Verification
The bench builds the block with `RST_MIN_US`=40, `SAMPLE_US`=6, `PRES_DELAY_US`=4 and `PRES_WIDTH_US`=8, and with a tick on every second clock. With these values, every low duration from one tick to beyond the reset threshold can be swept slot by slot. All 256 word values can be sent, and the reset and presence sequence repeats many times in a short run. Durations within one tick of the sample point or of the reset threshold are skipped, because the synchronizer latency makes those cases ambiguous. The sweep also covers back-pressure with replacement, a reset that cuts into a partial word, and master edges during the presence delay and the presence pulse.

// File: rtl/swr_pkg.sv
`timescale 1ns/1ps
package swr_pkg;
  typedef enum logic [1:0] {
    PR_IDLE  = 2'd0,
    PR_WAIT  = 2'd1,
    PR_DRIVE = 2'd2
  } pres_state_e;
endpackage

// File: rtl/swr_sync.sv
`timescale 1ns/1ps
// Brings the pad level into the clock domain and flags its edges.
module swr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  output logic bus_s,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= bus_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= chain[STAGES-1];

  assign bus_s = chain[STAGES-1];
  assign fall  = last_q & ~bus_s;
  assign rise  = ~last_q & bus_s;
endmodule

// File: rtl/swr_slot_decode.sv
`timescale 1ns/1ps
// Times master low pulses: samples each slot, and recognizes a reset on release.
module swr_slot_decode #(
  parameter int RST_MIN_US = 480,
  parameter int SAMPLE_US  = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic bus_s,
  input  logic fall,
  input  logic rise,
  input  logic listen,
  output logic bit_vld,
  output logic bit_val,
  output logic rst_det
);
  localparam int LO_W = $clog2(RST_MIN_US + 1);
  localparam int SL_W = $clog2(SAMPLE_US + 1);
  localparam logic [LO_W-1:0] LO_MAX  = LO_W'(RST_MIN_US);
  localparam logic [SL_W-1:0] SL_LAST = SL_W'(SAMPLE_US - 1);

  logic            in_slot, samp_pend, zero_pend;
  logic [LO_W-1:0] lo_cnt;
  logic [SL_W-1:0] sl_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_slot   <= 1'b0;
      samp_pend <= 1'b0;
      zero_pend <= 1'b0;
      lo_cnt    <= '0;
      sl_cnt    <= '0;
      bit_vld   <= 1'b0;
      bit_val   <= 1'b0;
      rst_det   <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      rst_det <= 1'b0;
      if (fall && listen) begin
        in_slot   <= 1'b1;
        samp_pend <= 1'b1;
        zero_pend <= 1'b0;
        lo_cnt    <= '0;
        sl_cnt    <= '0;
      end else begin
        if (tick && in_slot && !bus_s && lo_cnt != LO_MAX)
          lo_cnt <= lo_cnt + 1'b1;
        if (tick && samp_pend) begin
          if (sl_cnt == SL_LAST) begin
            samp_pend <= 1'b0;
            if (bus_s) begin
              bit_vld <= 1'b1;
              bit_val <= 1'b1;
            end else begin
              zero_pend <= 1'b1;
            end
          end else begin
            sl_cnt <= sl_cnt + 1'b1;
          end
        end
        if (rise && in_slot) begin
          in_slot <= 1'b0;
          if (lo_cnt == LO_MAX) begin
            rst_det   <= 1'b1;
            zero_pend <= 1'b0;
            samp_pend <= 1'b0;
          end else if (zero_pend) begin
            bit_vld   <= 1'b1;
            bit_val   <= 1'b0;
            zero_pend <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/swr_presence.sv
`timescale 1ns/1ps
// Waits a fixed delay after a reset, then holds the bus low for a fixed width.
module swr_presence
  import swr_pkg::*;
#(
  parameter int PRES_DELAY_US = 30,
  parameter int PRES_WIDTH_US = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rst_det,
  output logic drive_low,
  output logic idle
);
  localparam int PMAX = (PRES_DELAY_US > PRES_WIDTH_US) ? PRES_DELAY_US : PRES_WIDTH_US;
  localparam int PC_W = $clog2(PMAX + 1);
  localparam logic [PC_W-1:0] D_LAST = PC_W'(PRES_DELAY_US - 1);
  localparam logic [PC_W-1:0] W_LAST = PC_W'(PRES_WIDTH_US - 1);

  pres_state_e     state;
  logic [PC_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PR_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        PR_IDLE: if (rst_det) begin
          state <= PR_WAIT;
          cnt   <= '0;
        end
        PR_WAIT: if (tick) begin
          if (cnt == D_LAST) begin
            state <= PR_DRIVE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PR_DRIVE: if (tick) begin
          if (cnt == W_LAST) begin
            state <= PR_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= PR_IDLE;
      endcase
    end
  end

  assign drive_low = (state == PR_DRIVE);
  assign idle      = (state == PR_IDLE);
endmodule

// File: rtl/swr_shifter.sv
`timescale 1ns/1ps
// Packs bits first-in-lowest and offers each finished word on valid/ready.
module swr_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-2:0] sr;
  logic              word_done;

  assign word_done = bit_vld && !clr && (bit_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      sr      <= '0;
    end else if (clr) begin
      bit_cnt <= '0;
    end else if (bit_vld) begin
      sr      <= {bit_val, sr[DATA_W-2:1]};
      bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (word_done) begin
      out_valid <= 1'b1;
      out_data  <= {bit_val, sr};
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/swr_responder.sv
`timescale 1ns/1ps
module swr_responder #(
  parameter int DATA_W        = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int RST_MIN_US    = 480,
  parameter int SAMPLE_US     = 30,
  parameter int PRES_DELAY_US = 30,
  parameter int PRES_WIDTH_US = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              bus_in,
  output logic              drive_low,
  output logic              reset_seen,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic bus_s, fall, rise, listen;
  logic bit_vld, bit_val, rst_det;

  swr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
    .bus_s(bus_s), .fall(fall), .rise(rise)
  );

  swr_slot_decode #(.RST_MIN_US(RST_MIN_US), .SAMPLE_US(SAMPLE_US)) u_slot (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .bus_s(bus_s),
    .fall(fall), .rise(rise), .listen(listen),
    .bit_vld(bit_vld), .bit_val(bit_val), .rst_det(rst_det)
  );

  swr_presence #(.PRES_DELAY_US(PRES_DELAY_US), .PRES_WIDTH_US(PRES_WIDTH_US)) u_pres (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .rst_det(rst_det),
    .drive_low(drive_low), .idle(listen)
  );

  swr_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(rst_det), .bit_vld(bit_vld),
    .bit_val(bit_val), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data)
  );

  assign reset_seen = rst_det;
endmodule

// File: rtl/swr_responder_chk.sv
`timescale 1ns/1ps
module swr_responder_chk #(
  parameter int PRES_DELAY_US = 30,
  parameter int PRES_WIDTH_US = 120
) (
  input logic clk,
  input logic rst_n,
  input logic tick_us,
  input logic drive_low,
  input logic reset_seen,
  input logic out_valid,
  input logic out_ready
);
  logic [15:0] d_cnt, w_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_cnt <= '0;
      w_cnt <= '0;
    end else begin
      if (reset_seen)                               d_cnt <= '0;
      else if (tick_us && !drive_low && d_cnt != 16'hFFFF) d_cnt <= d_cnt + 1'b1;
      if (!drive_low)                               w_cnt <= '0;
      else if (tick_us)                             w_cnt <= w_cnt + 1'b1;
    end
  end

  p_flag_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seen |=> !reset_seen);

  p_flag_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seen |-> !drive_low);

  p_pres_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low) |-> (d_cnt == 16'(PRES_DELAY_US)));

  p_pres_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_low) |-> (w_cnt == 16'(PRES_WIDTH_US)));

  p_hold_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
endmodule

bind swr_responder swr_responder_chk #(
  .PRES_DELAY_US(PRES_DELAY_US),
  .PRES_WIDTH_US(PRES_WIDTH_US)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .drive_low(drive_low),
  .reset_seen(reset_seen), .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/swr_responder_tb.sv
`timescale 1ns/1ps
module swr_responder_tb;
  localparam int RST = 40;
  localparam int S   = 6;
  localparam int D   = 4;
  localparam int W   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       m_low = 1'b0;
  logic       out_ready = 1'b0;
  logic       bus_in, drive_low, reset_seen, out_valid;
  logic [7:0] out_data;

  int n_vec = 0, n_err = 0;
  int cyc = 0, rs_cnt = 0, rise_cnt = 0;
  int cyc_rs = 0, cyc_rise = 0, cyc_fall = 0;
  logic prev_drive = 1'b0;

  always #2 clk = ~clk;
  assign bus_in = ~(m_low | drive_low);

  swr_responder #(.DATA_W(8), .SYNC_STAGES(2), .RST_MIN_US(RST), .SAMPLE_US(S),
                  .PRES_DELAY_US(D), .PRES_WIDTH_US(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick), .bus_in(bus_in),
    .drive_low(drive_low), .reset_seen(reset_seen), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  always @(negedge clk) begin
    tick <= rst_n ? ~tick : 1'b0;
    cyc  <= cyc + 1;
    if (rst_n) begin
      if (reset_seen) begin rs_cnt <= rs_cnt + 1; cyc_rs <= cyc; end
      if (drive_low && !prev_drive) begin rise_cnt <= rise_cnt + 1; cyc_rise <= cyc; end
      if (!drive_low && prev_drive) cyc_fall <= cyc;
    end
    prev_drive <= drive_low;
  end

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    n_vec++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic slot(input int d);
    m_low = 1'b1;
    wait_ticks(d);
    m_low = 1'b0;
    wait_ticks((d < S) ? (S + 3 - d) : 3);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) slot(b[i] ? 2 : S + 4);
  endtask

  task automatic accept(input logic [7:0] exp, input string req);
    repeat (2) @(negedge clk);
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " data"}, int'(out_data), int'(exp));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R6 valid drops after accept", int'(out_valid), 0);
  endtask

  task automatic do_reset(input int len);
    int rs0, rr0;
    rs0 = rs_cnt; rr0 = rise_cnt;
    m_low = 1'b1;
    wait_ticks(len);
    m_low = 1'b0;
    wait_ticks(D + W + 6);
    check("R2 one reset_seen pulse", rs_cnt - rs0, 1);
    check("R3 one presence pulse", rise_cnt - rr0, 1);
    check_rng("R3 presence delay cycles", cyc_rise - cyc_rs, 2 * D, 2 * D + 1);
    check("R3 presence width cycles", cyc_fall - cyc_rise, 2 * W);
  endtask

  initial begin
    #800000;
    n_err++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    int rs0, rr0;
    repeat (5) @(negedge clk);
    check("R1 drive_low in reset", int'(drive_low), 0);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 reset_seen in reset", int'(reset_seen), 0);
    rst_n = 1'b1;
    wait_ticks(4);

    do_reset(RST + 4);
    do_reset(RST + 20);

    // R4 / R5: every word value through short and long slots
    for (int v = 0; v < 256; v++) begin
      send_byte(8'(v));
      accept(8'(v), "R5 word");
    end

    // R4 / R2: sweep the low duration of the first slot
    for (int d = 1; d <= RST + 6; d++) begin
      if ((d >= S - 1 && d <= S + 1) || (d >= RST - 1 && d <= RST + 1)) continue;
      if (d >= RST + 2) begin
        do_reset(d);
        send_byte(8'h5A);
        accept(8'h5A, "R8 word after reset");
      end else begin
        rs0 = rs_cnt;
        slot(d);
        for (int k = 0; k < 7; k++) slot(2);
        accept((d <= S - 2) ? 8'hFF : 8'hFE, "R4 slot decode");
        check("R2 no reset below threshold", rs_cnt - rs0, 0);
      end
    end

    // R8: reset cuts into a partial word
    slot(2); slot(2); slot(2);
    do_reset(RST + 4);
    check("R8 no word from partial bits", int'(out_valid), 0);
    send_byte(8'h00);
    accept(8'h00, "R8 restart at bit 0");

    // R9: master edges during presence delay and presence pulse
    rs0 = rs_cnt; rr0 = rise_cnt;
    m_low = 1'b1; wait_ticks(RST + 4); m_low = 1'b0;
    wait_ticks(1);
    m_low = 1'b1; wait_ticks(1); m_low = 1'b0;
    wait_ticks(4);
    m_low = 1'b1; wait_ticks(2); m_low = 1'b0;
    wait_ticks(W + 6);
    check("R9 single reset", rs_cnt - rs0, 1);
    check("R9 single presence", rise_cnt - rr0, 1);
    check("R9 no word from ignored edges", int'(out_valid), 0);
    send_byte(8'hA5);
    accept(8'hA5, "R9 word after presence");

    // R7 / R6: replacement and hold under back-pressure
    send_byte(8'h11);
    send_byte(8'h22);
    check("R7 valid kept", int'(out_valid), 1);
    check("R7 newer word kept", int'(out_data), 8'h22);
    repeat (10) @(negedge clk);
    check("R6 valid held", int'(out_valid), 1);
    check("R6 data held", int'(out_data), 8'h22);
    accept(8'h22, "R6 held word");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule